// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns single-register read and write requests from a host into serial management frames on the two-wire clock/data interface used to configure an Ethernet PHY. The host presents a PHY address, a register number, a direction and, for writes, a 16-bit value. It raises `req` for one cycle while `busy` is low. The block then produces the management clock (MDC) from the system clock and shifts the frame out. For reads it releases the data line and collects the PHY's reply.

Each frame has four parts, in this order: 32 preamble ones, a 14-bit header, a 2-bit turnaround and 16 data bits. The header carries, from most significant bit down, start code 01, a 2-bit opcode (01 write, 10 read), a 5-bit PHY address and a 5-bit register address. Every bit spends `HALF_CYC` system clocks with MDC low, then `HALF_CYC` clocks with MDC high. The outgoing value is set up while MDC is low. On reads, the incoming value is taken in the last low cycle before the clock rises. A one-cycle `done` pulse ends the transaction. At the same time, read data lands in a holding register.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is running, `mdc` is 0, `mdio_oe` is 1, `mdio_o` is 1, and `busy` and `done` are 0.
- R2: A request is taken only in a cycle where `req` is 1 and `busy` is 0. A `req` seen while `busy` is 1 changes neither the frame in flight nor the number of `done` pulses.
- R3: Every frame starts with 32 bits of value 1, one bit per MDC period.
- R4: The 14 bits after the preamble are sent most significant first: start code 01, then opcode 01 for a write (`req_rd`=0) or 10 for a read (`req_rd`=1), then `req_phy[4:0]`, then `req_reg[4:0]`.
- R5: A write frame sends turnaround 10 and then `req_wdata` most significant bit first, with `mdio_oe` at 1 for all 64 bits.
- R6: A read frame holds `mdio_oe` at 1 for the first 46 bits and at 0 for the two turnaround bits and the 16 data bits.
- R7: On a read, `mdio_i` is sampled in the last system cycle before each of the 16 data-bit rising edges of MDC, most significant bit first. Values on `mdio_i` during turnaround have no effect on `rd_data`.
- R8: Each bit is `HALF_CYC` system cycles with `mdc` low followed by `HALF_CYC` cycles with `mdc` high. A frame has exactly 64 MDC rising edges. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R9: `busy` is 1 from the cycle after acceptance until `done`. `done` is a single-cycle pulse that comes 128·`HALF_CYC` cycles after the accepting edge, and `busy` is 0 in that same cycle.
- R10: `rd_data` changes only together with the `done` of a read frame. A write frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, honoured when busy is low |
| req_rd | input | 1 | 1 = read frame, 0 = write frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address within the PHY |
| req_wdata | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Holding register for the last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of the frame contents. These are the idle line levels and the enable, the bounded width of MDC high runs, and the data line holding still while MDC is high. It also checks that `done` is a single pulse that ends `busy`, that `busy` starts only after a request, and that the holding register changes only on `done`. The bit-level contents can only be shown by the directed scenarios, which capture the line at each MDC rise and model a PHY. Those contents are the preamble, the header fields and opcodes, the turnaround pattern, the read release window, the sample point of the returned bits, the exact frame duration, and requests ignored while busy.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
   localparam int unsigned HDR_BITS  = 14;
   localparam int unsigned TA_BITS   = 2;
   localparam int unsigned REG_BITS  = 16;
   localparam int unsigned TAIL_BITS = HDR_BITS + TA_BITS + REG_BITS;

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] OPC_RD   = 2'b10;
   localparam logic [1:0] TURN_WR  = 2'b10;

   // Everything after the preamble, first bit to go out at the top.
   function automatic logic [TAIL_BITS-1:0] pack_tail(input logic rd,
                                                      input logic [4:0] phy,
                                                      input logic [4:0] rg,
                                                      input logic [REG_BITS-1:0] wd);
      return {SOF_CODE, (rd ? OPC_RD : OPC_WR), phy, rg,
              (rd ? 2'b00 : TURN_WR), (rd ? {REG_BITS{1'b0}} : wd)};
   endfunction
endpackage

// File: rtl/mdio_halfper.sv
`timescale 1ns/1ps
module mdio_halfper #(
   parameter int unsigned HALF_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CNT_W = 16;

   generate
      if (HALF_CYC == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (!run || tick)  cnt <= '0;
            else                    cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CNT_W'(HALF_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
   import mdio_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic        req_rd,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   input  logic        tick,
   output logic        busy,
   output logic        done,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        smp,
   output logic        fin_rd
);
   localparam int unsigned FRAME_LEN = PRE_LEN + TAIL_BITS;
   localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST    = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] HDR_END = IDX_W'(PRE_LEN + HDR_BITS);
   localparam logic [IDX_W-1:0] CAP_BEG = IDX_W'(PRE_LEN + HDR_BITS + TA_BITS);
   localparam logic [IDX_W-1:0] PRE_END = IDX_W'(PRE_LEN);

   logic                 phase_hi;
   logic [IDX_W-1:0]     idx;
   logic [TAIL_BITS-1:0] tail;
   logic                 is_rd;
   logic                 in_pre;

   assign in_pre = (idx < PRE_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         phase_hi <= 1'b0;
         idx      <= '0;
         tail     <= '0;
         is_rd    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (req) begin
               busy     <= 1'b1;
               phase_hi <= 1'b0;
               idx      <= '0;
               is_rd    <= req_rd;
               tail     <= pack_tail(req_rd, req_phy, req_reg, req_wdata);
            end
         end else if (tick) begin
            if (!phase_hi) begin
               phase_hi <= 1'b1;
            end else begin
               phase_hi <= 1'b0;
               if (idx == LAST) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  idx  <= '0;
               end else begin
                  idx <= idx + 1'b1;
                  if (!in_pre) tail <= {tail[TAIL_BITS-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign mdc     = busy && phase_hi;
   assign mdio_o  = in_pre ? 1'b1 : tail[TAIL_BITS-1];
   assign mdio_oe = !(busy && is_rd && (idx >= HDR_END));
   assign smp     = busy && tick && !phase_hi && is_rd && (idx >= CAP_BEG);
   assign fin_rd  = busy && tick && phase_hi && is_rd && (idx == LAST);
endmodule

// File: rtl/mdio_rdcap.sv
`timescale 1ns/1ps
module mdio_rdcap #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp,
   input  logic          fin_rd,
   input  logic          mdio_i,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         rd_data <= '0;
      end else begin
         if (smp)    shreg   <= {shreg[DW-2:0], mdio_i};
         if (fin_rd) rd_data <= shreg;
      end
   end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
   import mdio_pkg::*;
#(
   parameter int unsigned HALF_CYC = 40,
   parameter int unsigned PRE_LEN  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic        req_rd,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   output logic        busy,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (HALF_CYC < 1 || HALF_CYC > 65535) begin : g_bad_half
         $error("mdio_master: HALF_CYC must lie in 1..65535");
      end
      if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
         $error("mdio_master: PRE_LEN must lie in 1..32");
      end
   endgenerate

   logic tick, smp, fin_rd;

   mdio_halfper #(.HALF_CYC(HALF_CYC)) u_hp (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .tick(tick), .busy(busy), .done(done), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .smp(smp), .fin_rd(fin_rd)
   );

   mdio_rdcap #(.DW(REG_BITS)) u_cap (
      .clk(clk), .rst_n(rst_n), .smp(smp), .fin_rd(fin_rd),
      .mdio_i(mdio_i), .rd_data(rd_data)
   );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
   parameter int unsigned HALF_CYC = 40
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req,
   input logic        busy,
   input logic        done,
   input logic [15:0] rd_data,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);
   logic [16:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_run <= '0;
      else if (mdc) hi_run <= hi_run + 1'b1;
      else          hi_run <= '0;
   end

   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && mdio_oe && mdio_o));
   a_r2_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req));
   a_r8_hold_when_high: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
   a_r8_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> (hi_run < 17'(HALF_CYC)));
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   a_r10_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rd_data));
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
   .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
   localparam int H = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, req_rd = 1'b0;
   logic [4:0] req_phy = '0, req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic mdio_i = 1'b1;
   wire busy, done, mdc, mdio_o, mdio_oe;
   wire [15:0] rd_data;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   mdio_master #(.HALF_CYC(H)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // capture of the line at each MDC rise, plus a simple PHY reply model
   logic cap_on = 1'b0;
   int   ecnt = 0;
   logic [63:0] cap_o, cap_oe;
   logic [15:0] phy_rd = '0;

   always @(posedge mdc) begin
      if (cap_on && ecnt < 64) begin
         cap_o[63-ecnt]  = mdio_o;
         cap_oe[63-ecnt] = mdio_oe;
         if (ecnt == 45 || ecnt == 46) mdio_i = ~phy_rd[15]; // junk in turnaround
         else if (ecnt >= 47 && ecnt <= 62) mdio_i = phy_rd[62-ecnt];
         else if (ecnt == 63) mdio_i = 1'b1;
      end
      ecnt++;
   end

   int hicnt = 0;
   always @(negedge clk) if (cap_on && mdc) hicnt++;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] w);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
              (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : w)};
   endfunction

   // one frame; optional stray request while busy
   task automatic run_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] w, input logic [15:0] reply,
                            input logic poke, output logic [15:0] got);
      int n;
      int dones;
      logic [63:0] ef, eoe;
      phy_rd = reply;
      ecnt = 0; hicnt = 0; cap_on = 1'b1;
      cap_o = '0; cap_oe = '0;
      @(negedge clk);
      req = 1'b1; req_rd = rd; req_phy = p; req_reg = r; req_wdata = w;
      @(negedge clk);
      req = 1'b0;
      check("R9 busy after accept", {63'd0, busy}, 64'd1);
      n = 1; dones = 0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
         if (poke && n == 100) begin
            req = 1'b1; req_rd = ~rd; req_phy = ~p; req_reg = ~r; req_wdata = ~w;
         end else req = 1'b0;
      end
      got = rd_data;
      check("R9 frame duration", 64'(n), 64'(128*H+1));
      check("R9 busy low at done", {63'd0, busy}, 64'd0);
      cap_on = 1'b0;
      ef = exp_frame(rd, p, r, w);
      eoe = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : {64{1'b1}};
      check("R3 preamble", {32'd0, cap_o[63:32]}, {32'd0, ef[63:32]});
      check("R4 header", {50'd0, cap_o[31:18]}, {50'd0, ef[31:18]});
      if (!rd) check("R5 turnaround and data", {46'd0, cap_o[17:0]}, {46'd0, ef[17:0]});
      check(rd ? "R6 read enable pattern" : "R5 write enable", cap_oe, eoe);
      check("R8 rising edge count", 64'(ecnt), 64'd64);
      check("R8 high time", 64'(hicnt), 64'(64*H));
      // look for stray second completion
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (done) dones++;
         if (busy) dones++;
      end
      check("R2 no second frame", 64'(dones), 64'd0);
   endtask

   task automatic t_reset;
      check("R1 reset mdc", {63'd0, mdc}, 64'd0);
      check("R1 reset oe", {63'd0, mdio_oe}, 64'd1);
      check("R1 reset mdio_o", {63'd0, mdio_o}, 64'd1);
      check("R1 reset busy/done", {62'd0, busy, done}, 64'd0);
   endtask

   task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] w,
                          input logic [15:0] keep);
      logic [15:0] got;
      run_frame(1'b0, p, r, w, 16'h0, 1'b0, got);
      check("R10 write keeps rd_data", {48'd0, got}, {48'd0, keep});
      check("R1 idle after frame", {61'd0, mdc, mdio_oe, mdio_o}, 64'd3);
   endtask

   task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v);
      logic [15:0] got;
      run_frame(1'b1, p, r, 16'hFFFF, v, 1'b0, got);
      check("R7 read data", {48'd0, got}, {48'd0, v});
   endtask

   task automatic t_busy_poke;
      logic [15:0] got;
      run_frame(1'b0, 5'h0A, 5'h03, 16'h1234, 16'h0, 1'b1, got);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write(5'h01, 5'h00, 16'hA5C3, 16'h0000);
      t_write(5'h1F, 5'h1F, 16'h0001, 16'h0000);
      t_read(5'h02, 5'h01, 16'h8001);
      t_write(5'h00, 5'h04, 16'hFFFF, 16'h8001);
      t_read(5'h15, 5'h0A, 16'h5A3C);
      t_read(5'h03, 5'h02, 16'h0000);
      t_busy_poke();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule